// File: doc/BRIEF.md
# Lookup-Table Refill Engine

This block rewrites rectangular regions of a page-translation lookup table without processor involvement. Software places a chain of descriptors in memory and writes the address of the first one to an engine's start register. A single shared walker then reads each descriptor through a memory read port. A descriptor names a slot rectangle with inclusive corners, a table id, a data pointer and a link to the next descriptor. For every slot the walker reads one 32-bit physical address from the data array and writes it into the table through a write port.

Each engine has its own start register, a ready flag and a sticky error flag. Results are also recorded in a per-engine 8-bit lane of an interrupt status word, whose bits are cleared by writing ones. When several engines have work waiting, the lowest-numbered engine is served first. A chain is cut short by writing zero to its start register.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset every present engine is ready with its error flag clear. The interrupt status is zero, each present lane of the interrupt enable reads 0x7E, and `irq` is low. Register map: start registers at `reg_addr` 0..3, status at 4, interrupt status at 5, interrupt enable at 6. In the status register, lane n (bits [8n+7:8n]) has bit 0 = ready and bit 1 = error.
- R2: A descriptor is four 32-bit words at a 16-byte-aligned address: word0 = {y1,x1,y0,x0} (8 bits each, x0 in bits [7:0]); word1 = control (bit 0 start, bits [9:8] table id); word2 = data pointer; word3 = next pointer. Slots are visited row by row, x fastest. Slot k is written with the data word at data pointer + 4k, at `lut_addr` = {id[1:0], y[6:0], x[7:0]}.
- R3: The walker follows next pointers. A next pointer of 0 ends the chain, and each descriptor uses its own table id.
- R4: Ready drops in the cycle after the start register is written. With a memory that answers one cycle after each request, a one-descriptor chain of S slots raises ready again exactly 11+2S clock edges after the write edge, and not before.
- R5: When a chain completes, bit 4 of the engine's interrupt status lane is set in the same cycle that ready returns, and `irq` rises when that bit is enabled.
- R6: Writing the interrupt status register clears exactly the bits written as 1. All other bits are unaffected.
- R7: A status bit is latched even when its enable is 0. `irq` is the OR of the status bits whose enable is set.
- R8: A start address or a non-zero next pointer that is not 16-byte aligned sets the engine's error flag and bit 3 of its interrupt lane. The walk then stops, and slots already written remain. A later non-zero start clears the error flag.
- R9: A descriptor with x1<x0 or y1<y0 sets the error flag and bit 3 without writing any slot.
- R10: Writing 0 to the start register of the active engine stops the walk: no further table writes follow, ready returns at once, and no completion bit is set.
- R11: A descriptor whose start bit is 0 writes no slots, and the chain continues through its next pointer.
- R12: When several engines are pending, the lowest-numbered one is served first. Each engine sets the completion bit in its own lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| lut_we | output | 1 | Table write strobe |
| lut_addr | output | 17 | Table slot address {id, y, x} |
| lut_wdata | output | 32 | Physical address written to the slot |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
Register writes take effect on the clock edge that samples them. The bench reads status through the combinational read port one step after that edge. Ready is expected low right after the start write, and the bench counts 10+2S further edges to confirm ready is still low, then one more edge to see ready and the completion bit appear together. Table writes are logged at the edge where `lut_we` is high and compared in order against slot addresses and data computed from the descriptor. Abort and error cases are judged by the log length staying fixed over a long idle window afterwards.

// File: rtl/lre_pkg.sv
package lre_pkg;
    localparam int MAX_ENG  = 4;
    localparam int LANE_W   = 8;
    localparam int DONE_BIT = 4;
    localparam int ERR_BIT  = 3;
    localparam logic [7:0] IRQ_EN_RESET = 8'h7E;

    localparam logic [2:0] RA_STATUS   = 3'd4;
    localparam logic [2:0] RA_IRQ_STAT = 3'd5;
    localparam logic [2:0] RA_IRQ_EN   = 3'd6;

    typedef enum logic [2:0] {
        W_IDLE, W_FETCH, W_FWAIT, W_CHECK, W_SREQ, W_SWAIT, W_NEXT, W_DRAIN
    } walk_state_e;

    typedef struct packed {
        logic [7:0] y1;
        logic [7:0] x1;
        logic [7:0] y0;
        logic [7:0] x0;
    } rect_t;

    function automatic logic is_aligned16(input logic [31:0] a);
        return a[3:0] == 4'h0;
    endfunction

    function automatic logic rect_bad(input rect_t r);
        return (r.x1 < r.x0) || (r.y1 < r.y0);
    endfunction
endpackage

// File: rtl/lre_arb.sv
module lre_arb #(
    parameter int NUM_ENG = 2
) (
    input  logic [NUM_ENG-1:0] req,
    output logic [NUM_ENG-1:0] gnt,
    output logic               gnt_any,
    output logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] gnt_idx
);
    localparam int ENG_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int e = NUM_ENG - 1; e >= 0; e--) begin
            if (req[e]) begin
                gnt     = '0;
                gnt[e]  = 1'b1;
                gnt_idx = ENG_W'(e);
            end
        end
    end

    assign gnt_any = |req;
endmodule

// File: rtl/lre_regs.sv
module lre_regs
    import lre_pkg::*;
#(
    parameter int NUM_ENG = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [2:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    input  logic [2:0]               reg_raddr,
    output logic [31:0]              reg_rdata,
    input  logic                     take,
    input  logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] take_idx,
    input  logic                     w_active,
    input  logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] w_cur,
    input  logic                     done_ev,
    input  logic                     err_ev,
    input  logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] ev_eng,
    output logic [NUM_ENG-1:0]       pend,
    output logic [NUM_ENG-1:0][31:0] pend_addr,
    output logic [NUM_ENG-1:0]       ready,
    output logic [31:0]              irq_stat,
    output logic                     abort,
    output logic                     start_wr,
    output logic                     irq
);
    localparam int ENG_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

    logic [NUM_ENG-1:0] err_flag;
    logic [31:0]        irq_en;
    logic [31:0]        irq_next;
    logic [31:0]        status;

    assign start_wr = reg_wr && !reg_addr[2];
    assign abort    = reg_wr && w_active && (reg_addr == 3'(w_cur));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            pend_addr <= '0;
            err_flag <= '0;
        end else begin
            for (int e = 0; e < NUM_ENG; e++) begin
                if (reg_wr && reg_addr == 3'(e)) begin
                    pend[e]      <= (reg_wdata != 32'h0);
                    pend_addr[e] <= reg_wdata;
                end else if (take && take_idx == ENG_W'(e)) begin
                    pend[e] <= 1'b0;
                end
                if (err_ev && ev_eng == ENG_W'(e))
                    err_flag[e] <= 1'b1;
                else if (reg_wr && reg_addr == 3'(e) && reg_wdata != 32'h0)
                    err_flag[e] <= 1'b0;
            end
        end
    end

    always_comb begin
        irq_next = irq_stat;
        if (reg_wr && reg_addr == RA_IRQ_STAT)
            irq_next = irq_stat & ~reg_wdata;
        for (int e = 0; e < NUM_ENG; e++) begin
            if (done_ev && ev_eng == ENG_W'(e))
                irq_next[LANE_W*e + DONE_BIT] = 1'b1;
            if (err_ev && ev_eng == ENG_W'(e))
                irq_next[LANE_W*e + ERR_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_stat <= '0;
            for (int e = 0; e < MAX_ENG; e++)
                irq_en[LANE_W*e +: LANE_W] <= (e < NUM_ENG) ? IRQ_EN_RESET : 8'h00;
        end else begin
            irq_stat <= irq_next;
            if (reg_wr && reg_addr == RA_IRQ_EN)
                irq_en <= reg_wdata;
        end
    end

    always_comb begin
        status = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            ready[e]              = !pend[e] && !(w_active && w_cur == ENG_W'(e));
            status[LANE_W*e]      = ready[e];
            status[LANE_W*e + 1]  = err_flag[e];
        end
    end

    always_comb begin
        case (reg_raddr)
            RA_STATUS:   reg_rdata = status;
            RA_IRQ_STAT: reg_rdata = irq_stat;
            RA_IRQ_EN:   reg_rdata = irq_en;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = |(irq_stat & irq_en);
endmodule

// File: rtl/lre_walker.sv
module lre_walker
    import lre_pkg::*;
#(
    parameter int NUM_ENG     = 2,
    parameter int X_BITS      = 8,
    parameter int Y_BITS      = 7,
    parameter int LUT_ID_BITS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] start_eng,
    input  logic [31:0] start_addr,
    input  logic        abort,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        lut_we,
    output logic [LUT_ID_BITS+Y_BITS+X_BITS-1:0] lut_addr,
    output logic [31:0] lut_wdata,
    output logic        busy,
    output logic        active,
    output logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] cur_eng,
    output logic        done_ev,
    output logic        err_ev,
    output logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] ev_eng
);
    walk_state_e            state;
    logic [31:0]            ptr;
    logic [1:0]             widx;
    rect_t                  rect;
    logic                   c_start;
    logic [LUT_ID_BITS-1:0] c_lut;
    logic [31:0]            dptr;
    logic [31:0]            nxt;
    logic [7:0]             x;
    logic [7:0]             y;

    assign busy    = (state != W_IDLE);
    assign active  = busy && (state != W_DRAIN);
    assign mem_req = (state == W_FETCH) || (state == W_SREQ);
    assign mem_addr = (state == W_SREQ) ? dptr : ptr + 32'({widx, 2'b00});

    assign ev_eng  = (state == W_IDLE) ? start_eng : cur_eng;
    assign done_ev = (state == W_NEXT) && (nxt == 32'h0) && !abort;
    assign err_ev  = ((state == W_IDLE) && start && !is_aligned16(start_addr)) ||
                     (!abort && (state == W_CHECK) && rect_bad(rect)) ||
                     (!abort && (state == W_NEXT) && (nxt != 32'h0) && !is_aligned16(nxt));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            ptr       <= '0;
            widx      <= '0;
            rect      <= '0;
            c_start   <= 1'b0;
            c_lut     <= '0;
            dptr      <= '0;
            nxt       <= '0;
            x         <= '0;
            y         <= '0;
            cur_eng   <= '0;
            lut_we    <= 1'b0;
            lut_addr  <= '0;
            lut_wdata <= '0;
        end else begin
            lut_we <= 1'b0;
            if (abort && active) begin
                state <= ((state == W_FWAIT || state == W_SWAIT) && !mem_rvalid)
                         ? W_DRAIN : W_IDLE;
            end else begin
                case (state)
                    W_IDLE: if (start) begin
                        cur_eng <= start_eng;
                        ptr     <= start_addr;
                        widx    <= '0;
                        state   <= is_aligned16(start_addr) ? W_FETCH : W_IDLE;
                    end
                    W_FETCH: state <= W_FWAIT;
                    W_FWAIT: if (mem_rvalid) begin
                        case (widx)
                            2'd0: rect <= mem_rdata;
                            2'd1: begin
                                c_start <= mem_rdata[0];
                                c_lut   <= mem_rdata[8 +: LUT_ID_BITS];
                            end
                            2'd2: dptr <= mem_rdata;
                            default: nxt <= mem_rdata;
                        endcase
                        if (widx == 2'd3) begin
                            state <= W_CHECK;
                        end else begin
                            widx  <= widx + 2'd1;
                            state <= W_FETCH;
                        end
                    end
                    W_CHECK: begin
                        if (rect_bad(rect)) begin
                            state <= W_IDLE;
                        end else if (!c_start) begin
                            state <= W_NEXT;
                        end else begin
                            x     <= rect.x0;
                            y     <= rect.y0;
                            state <= W_SREQ;
                        end
                    end
                    W_SREQ: state <= W_SWAIT;
                    W_SWAIT: if (mem_rvalid) begin
                        lut_we    <= 1'b1;
                        lut_addr  <= {c_lut, y[Y_BITS-1:0], x[X_BITS-1:0]};
                        lut_wdata <= mem_rdata;
                        dptr      <= dptr + 32'd4;
                        if (x == rect.x1) begin
                            x <= rect.x0;
                            if (y == rect.y1) begin
                                state <= W_NEXT;
                            end else begin
                                y     <= y + 8'd1;
                                state <= W_SREQ;
                            end
                        end else begin
                            x     <= x + 8'd1;
                            state <= W_SREQ;
                        end
                    end
                    W_NEXT: begin
                        if (nxt == 32'h0 || !is_aligned16(nxt)) begin
                            state <= W_IDLE;
                        end else begin
                            ptr   <= nxt;
                            widx  <= '0;
                            state <= W_FETCH;
                        end
                    end
                    W_DRAIN: if (mem_rvalid) state <= W_IDLE;
                    default: state <= W_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lut_refill_engine.sv
module lut_refill_engine
    import lre_pkg::*;
#(
    parameter int NUM_ENG     = 2,
    parameter int X_BITS      = 8,
    parameter int Y_BITS      = 7,
    parameter int LUT_ID_BITS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        lut_we,
    output logic [LUT_ID_BITS+Y_BITS+X_BITS-1:0] lut_addr,
    output logic [31:0] lut_wdata,
    output logic        irq
);
    localparam int ENG_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

    logic [NUM_ENG-1:0]       pend;
    logic [NUM_ENG-1:0][31:0] pend_addr;
    logic [NUM_ENG-1:0]       eng_ready;
    logic [NUM_ENG-1:0]       arb_req;
    logic [NUM_ENG-1:0]       gnt;
    logic                     gnt_any;
    logic [ENG_W-1:0]         gnt_idx;
    logic                     w_busy;
    logic                     w_active;
    logic [ENG_W-1:0]         w_cur;
    logic                     done_ev;
    logic                     err_ev;
    logic [ENG_W-1:0]         ev_eng;
    logic                     abort;
    logic                     start_wr;
    logic [31:0]              irq_stat;

    assign arb_req = pend & {NUM_ENG{!w_busy && !start_wr}};

    lre_arb #(.NUM_ENG(NUM_ENG)) u_arb (
        .req     (arb_req),
        .gnt     (gnt),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    lre_regs #(.NUM_ENG(NUM_ENG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .take      (gnt_any),
        .take_idx  (gnt_idx),
        .w_active  (w_active),
        .w_cur     (w_cur),
        .done_ev   (done_ev),
        .err_ev    (err_ev),
        .ev_eng    (ev_eng),
        .pend      (pend),
        .pend_addr (pend_addr),
        .ready     (eng_ready),
        .irq_stat  (irq_stat),
        .abort     (abort),
        .start_wr  (start_wr),
        .irq       (irq)
    );

    lre_walker #(
        .NUM_ENG     (NUM_ENG),
        .X_BITS      (X_BITS),
        .Y_BITS      (Y_BITS),
        .LUT_ID_BITS (LUT_ID_BITS)
    ) u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (gnt_any),
        .start_eng  (gnt_idx),
        .start_addr (pend_addr[gnt_idx]),
        .abort      (abort),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .lut_we     (lut_we),
        .lut_addr   (lut_addr),
        .lut_wdata  (lut_wdata),
        .busy       (w_busy),
        .active     (w_active),
        .cur_eng    (w_cur),
        .done_ev    (done_ev),
        .err_ev     (err_ev),
        .ev_eng     (ev_eng)
    );
endmodule

// File: rtl/lre_checker.sv
module lre_checker
    import lre_pkg::*;
#(
    parameter int NUM_ENG = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [2:0]         reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               mem_req,
    input logic               lut_we,
    input logic               w_active,
    input logic [((NUM_ENG > 1) ? $clog2(NUM_ENG) : 1)-1:0] w_cur,
    input logic [NUM_ENG-1:0] ready,
    input logic [NUM_ENG-1:0] gnt,
    input logic [31:0]        irq_stat,
    input logic               done_ev,
    input logic               err_ev
);
    // R2: one read outstanding, so requests never come back to back
    a_r2_read_spacing: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R4: the engine being walked never reports ready
    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        w_active |-> !ready[w_cur]);

    // R6: bits written as 1 are zero afterwards when no event sets them
    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_IRQ_STAT && !done_ev && !err_ev)
        |=> ((irq_stat & $past(reg_wdata)) == 32'h0));

    // R10: a write to the active engine's start register stops table writes
    a_r10_abort_stops: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && w_active && reg_addr == 3'(w_cur)) |=> !lut_we);

    // R12: at most one engine granted at a time
    a_r12_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
endmodule

bind lut_refill_engine lre_checker #(.NUM_ENG(NUM_ENG)) u_lre_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .lut_we    (lut_we),
    .w_active  (w_active),
    .w_cur     (w_cur),
    .ready     (eng_ready),
    .gnt       (gnt),
    .irq_stat  (irq_stat),
    .done_ev   (done_ev),
    .err_ev    (err_ev)
);

// File: tb/test_lut_refill_engine.sv
module test_lut_refill_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        lut_we;
    logic [16:0] lut_addr;
    logic [31:0] lut_wdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [31:0] mem [0:1023];
    logic [16:0] log_a [0:63];
    logic [31:0] log_d [0:63];
    int          log_n = 0;

    always #2 clk = ~clk;

    lut_refill_engine i_lut_refill_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .lut_we(lut_we), .lut_addr(lut_addr),
        .lut_wdata(lut_wdata), .irq(irq)
    );

    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[11:2]];
        if (lut_we && log_n < 64) begin
            log_a[log_n] <= lut_addr;
            log_d[log_n] <= lut_wdata;
        end
        if (lut_we) log_n <= log_n + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            fails = fails + 1;
            $display("FAIL watchdog R4 actual=%0d cycles expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a; #1;
        d = reg_rdata;
    endtask

    task automatic put_desc(input int a, input int x0, input int y0, input int x1,
                            input int y1, input int lut, input bit st,
                            input int data, input int nxt);
        mem[a/4]     = {8'(y1), 8'(x1), 8'(y0), 8'(x0)};
        mem[a/4 + 1] = {22'h0, 2'(lut), 7'h0, st};
        mem[a/4 + 2] = 32'(data);
        mem[a/4 + 3] = 32'(nxt);
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'hD000_0000 | 32'(a);
    endfunction

    task automatic fill_data(input int base, input int n);
        for (int k = 0; k < n; k++) mem[base/4 + k] = pat(base + 4*k);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd4, s);
            if ((s & 32'h0101) == 32'h0101) return;
            @(posedge clk); #1;
        end
        chk(0, "R4 idle timeout", s, 32'h0101);
    endtask

    // compare logged writes starting at idx against a rectangle walk
    task automatic chk_rect(inout int idx, input int lut, input int x0, input int y0,
                            input int x1, input int y1, input int data, input string req);
        int k = 0;
        for (int y = y0; y <= y1; y++) begin
            for (int x = x0; x <= x1; x++) begin
                logic [16:0] ea;
                ea = {2'(lut), 7'(y), 8'(x)};
                chk(log_a[idx] == ea, req, 32'(log_a[idx]), 32'(ea));
                chk(log_d[idx] == pat(data + 4*k), req, log_d[idx], pat(data + 4*k));
                idx++; k++;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd4, v); chk(v == 32'h0000_0101, "R1 status", v, 32'h0000_0101);
        rd(3'd5, v); chk(v == 32'h0, "R1 irq status", v, 32'h0);
        rd(3'd6, v); chk(v == 32'h0000_7E7E, "R1 irq enable", v, 32'h0000_7E7E);
        chk(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int idx = log_n;
        int s = 6;
        put_desc(32'h100, 2, 5, 4, 6, 1, 1, 32'h200, 0);
        fill_data(32'h200, s);
        wr(3'd0, 32'h100);
        rd(3'd4, v); chk(v[0] == 1'b0, "R4 ready low after start", v, 32'h0);
        repeat (10 + 2*s) @(posedge clk);
        #1; rd(3'd4, v); chk(v[0] == 1'b0, "R4 ready still low", v, 32'h0);
        @(posedge clk); #1;
        rd(3'd4, v); chk(v[0] == 1'b1, "R4 ready on time", v, 32'h1);
        rd(3'd5, v); chk(v == 32'h10, "R5 done bit", v, 32'h10);
        chk(irq == 1'b1, "R5 irq", 32'(irq), 32'h1);
        chk(log_n == idx + s, "R2 slot count", log_n, idx + s);
        chk_rect(idx, 1, 2, 5, 4, 6, 32'h200, "R2 slot order");
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        int idx = log_n;
        put_desc(32'h140, 10, 0, 11, 0, 2, 1, 32'h240, 0);
        fill_data(32'h240, 2);
        wr(3'd1, 32'h140);
        wait_idle();
        chk_rect(idx, 2, 10, 0, 11, 0, 32'h240, "R2 engine1 slots");
        rd(3'd5, v); chk(v == 32'h1010, "R12 lane done bits", v, 32'h1010);
        wr(3'd5, 32'h10);
        rd(3'd5, v); chk(v == 32'h1000, "R6 partial clear", v, 32'h1000);
        wr(3'd5, 32'h1000);
        rd(3'd5, v); chk(v == 32'h0, "R6 full clear", v, 32'h0);
        chk(irq == 1'b0, "R6 irq low", 32'(irq), 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(3'd6, 32'h0);
        wr(3'd0, 32'h100);
        wait_idle();
        rd(3'd5, v); chk(v == 32'h10, "R7 latched while masked", v, 32'h10);
        chk(irq == 1'b0, "R7 irq masked", 32'(irq), 32'h0);
        wr(3'd6, 32'h10);
        chk(irq == 1'b1, "R7 irq enabled", 32'(irq), 32'h1);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'h7E7E);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        int idx = log_n;
        put_desc(32'h180, 0, 0, 1, 0, 0, 1, 32'h280, 32'h190);
        put_desc(32'h190, 5, 5, 6, 6, 1, 0, 32'h2C0, 32'h1A0);
        put_desc(32'h1A0, 254, 127, 255, 127, 3, 1, 32'h2E0, 0);
        fill_data(32'h280, 2);
        fill_data(32'h2C0, 4);
        fill_data(32'h2E0, 2);
        wr(3'd0, 32'h180);
        wait_idle();
        chk(log_n == idx + 4, "R11 skipped descriptor writes nothing", log_n, idx + 4);
        chk_rect(idx, 0, 0, 0, 1, 0, 32'h280, "R3 first link");
        chk_rect(idx, 3, 254, 127, 255, 127, 32'h2E0, "R3 last link");
        rd(3'd5, v); chk(v == 32'h10, "R3 chain done", v, 32'h10);
        wr(3'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        int idx = log_n;
        wr(3'd0, 32'h104);
        wait_idle();
        rd(3'd4, v); chk(v[1] == 1'b1, "R8 misaligned start error", v, 32'h2);
        rd(3'd5, v); chk(v == 32'h08, "R8 error irq bit", v, 32'h08);
        chk(log_n == idx, "R8 no writes", log_n, idx);
        wr(3'd5, 32'hFFFF_FFFF);
        put_desc(32'h1C0, 7, 3, 7, 3, 0, 1, 32'h300, 32'h1D8);
        fill_data(32'h300, 1);
        wr(3'd0, 32'h1C0);
        rd(3'd4, v); chk(v[1] == 1'b0, "R8 error cleared by new start", v, 32'h0);
        wait_idle();
        chk(log_n == idx + 1, "R8 slots before bad link kept", log_n, idx + 1);
        chk_rect(idx, 0, 7, 3, 7, 3, 32'h300, "R8 first link slot");
        rd(3'd5, v); chk(v == 32'h08, "R8 bad next pointer", v, 32'h08);
        wr(3'd5, 32'hFFFF_FFFF);
        put_desc(32'h1E0, 3, 0, 2, 0, 0, 1, 32'h300, 0);
        wr(3'd0, 32'h1E0);
        wait_idle();
        rd(3'd4, v); chk(v[1] == 1'b1, "R9 bounds error flag", v, 32'h2);
        rd(3'd5, v); chk(v == 32'h08, "R9 bounds irq bit", v, 32'h08);
        chk(log_n == idx, "R9 no writes", log_n, idx);
        wr(3'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int n0;
        int idx = log_n;
        put_desc(32'h400, 0, 0, 7, 3, 1, 1, 32'h500, 0);
        fill_data(32'h500, 32);
        wr(3'd0, 32'h400);
        repeat (30) @(posedge clk);
        #1;
        wr(3'd0, 32'h0);
        n0 = log_n;
        rd(3'd4, v); chk(v[0] == 1'b1, "R10 ready after abort", v, 32'h1);
        repeat (100) @(posedge clk);
        #1;
        chk(log_n == n0, "R10 no writes after abort", log_n, n0);
        chk(n0 > idx && n0 < idx + 32, "R10 partial walk", n0 - idx, 32'd10);
        rd(3'd5, v); chk(v == 32'h0, "R10 no done bit", v, 32'h0);
    endtask

    task automatic t_two_eng();
        logic [31:0] v;
        int idx = log_n;
        put_desc(32'h600, 1, 1, 1, 1, 2, 1, 32'h700, 0);
        put_desc(32'h610, 9, 9, 9, 9, 1, 1, 32'h710, 0);
        fill_data(32'h700, 1);
        fill_data(32'h710, 1);
        wr(3'd1, 32'h610);
        wr(3'd0, 32'h600);
        wait_idle();
        chk(log_n == idx + 2, "R12 both served", log_n, idx + 2);
        chk_rect(idx, 2, 1, 1, 1, 1, 32'h700, "R12 engine0 first");
        chk_rect(idx, 1, 9, 9, 9, 9, 32'h710, "R12 engine1 second");
        rd(3'd5, v); chk(v == 32'h1010, "R12 own lanes", v, 32'h1010);
        wr(3'd5, 32'hFFFF_FFFF);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        t_reset();
        t_single();
        t_w1c();
        t_mask();
        t_chain();
        t_errors();
        t_abort();
        t_two_eng();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule